// File: doc/BRIEF.md
# Six-Source Interrupt Request Controller

This block gathers interrupt requests for a small CPU core and turns them into one pending vector at a time. Six sources feed it: two external request lines, overflow pulses from three timers and the receive/transmit completion pulses of a serial port. The third timer adds a second pulse, an external capture or reload event. The block keeps one flag per request. An 8-bit enable byte, written and read over a simple register strobe, has one bit per source and a master bit. The block gates the flags through the enables and presents the highest-priority pending source as a 3-bit vector index with a valid strobe. The core answers with an acknowledge.

On acknowledge, the block clears the flags that the hardware owns: the two fast timers and any external line set to edge mode. The serial flags and both third-timer flags stay set until software clears them through a clear strobe. Their vector is therefore presented again until the handler removes the cause. The two fast timers reach the request logic one cycle later than the third timer. A vector, once issued, is held and not replaced until it is acknowledged.

Top module: `irq_hub`

## Requirements
- R1: Vector codes are external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, timer 2 = 5. When several enabled requests are pending, the lowest code is issued.
- R2: The enable byte holds the per-source enable for vector code k in bit k (bits 0 to 5). It is written by `en_wr` with `en_wdata` at a clock edge and reads back on `en_rdata`.
- R3: Bit 7 of the enable byte is the master enable. While it is 0, no vector is issued, whatever the flags and per-source bits are.
- R4: Bit 6 of the enable byte is reserved. A write to it has no effect, and it always reads 0.
- R5: After reset, the enable byte reads 0x00, `irq_valid` is 0 and every flag is clear.
- R6: Timing. A timer 2 overflow pulse in cycle N sets its flag at the end of cycle N, and `irq_valid` rises one edge later. A timer 0 or timer 1 overflow pulse in cycle N sets its flag one edge later, and `irq_valid` rises two edges after the end of cycle N.
- R7: The timer 2 request is the OR of its overflow flag and its external-event flag. Acknowledge clears neither flag. `sw_clr` bit 0 clears the overflow flag and bit 1 clears the event flag.
- R8: Acknowledging vector 1 or 3 clears that timer's flag. Acknowledging vector 0 or 2 clears that external line's flag when the line is in edge mode.
- R9: The serial request is the OR of a receive flag and a transmit flag. Acknowledge clears neither. `sw_clr` bit 2 clears the receive flag and bit 3 clears the transmit flag.
- R10: `ext_edge[k]` = 0 selects level mode: the request follows the registered line. `ext_edge[k]` = 1 selects edge mode: a rising edge of the line sets a flag that stays set until it is acknowledged.
- R11: While `irq_valid` is 1 and `irq_ack` is 0, `irq_valid` stays 1 and `irq_vec` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one machine cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_line | input | 2 | External request lines, active high |
| ext_edge | input | 2 | Per-line mode: 1 = edge, 0 = level |
| tmr_ovf | input | 2 | Overflow pulses of timer 0 (bit 0) and timer 1 (bit 1) |
| t2_ovf | input | 1 | Timer 2 overflow pulse |
| t2_evt | input | 1 | Timer 2 external-event pulse |
| ser_rx | input | 1 | Serial receive-complete pulse |
| ser_tx | input | 1 | Serial transmit-complete pulse |
| sw_clr | input | 4 | Software flag clears: T2 overflow, T2 event, serial receive, serial transmit |
| en_wr | input | 1 | Enable byte write strobe |
| en_wdata | input | 8 | Enable byte write data |
| en_rdata | output | 8 | Enable byte readback |
| irq_valid | output | 1 | A vector is presented |
| irq_vec | output | 3 | Presented vector code |
| irq_ack | input | 1 | Vector taken by the core |

## Verification
The outputs fall due at three different depths. An external line or a timer 2 pulse applied before edge N shows on `irq_valid` after edge N+1. A timer 0 or timer 1 pulse shows after edge N+2. An acknowledge at edge A drops `irq_valid` at A, and a flag that is still set brings the vector back after A+1. The bench drives inputs on falling edges and reads outputs on the next falling edge after the edge that is due. It also checks one cycle early that the output has not yet changed, so any error in latency is caught.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC = 6;
  localparam int VEC_W = 3;
  localparam int EN_W  = 8;
  localparam int RSV_BIT = 6;
  localparam int MASTER_BIT = 7;
  localparam logic [EN_W-1:0] EN_KEEP = ~(EN_W'(1) << RSV_BIT);

  typedef enum logic [VEC_W-1:0] {
    V_EXT0 = 3'd0, V_TMR0 = 3'd1, V_EXT1 = 3'd2,
    V_TMR1 = 3'd3, V_SER  = 3'd4, V_TMR2 = 3'd5
  } vec_e;

  // lowest set index wins
  function automatic logic [VEC_W-1:0] first_pending(input logic [N_SRC-1:0] p);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (p[i]) r = VEC_W'(i);
    return r;
  endfunction

  function automatic logic [N_SRC-1:0] gate_req(input logic [N_SRC-1:0] req,
                                                input logic [EN_W-1:0] en);
    return en[MASTER_BIT] ? (req & en[N_SRC-1:0]) : '0;
  endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ext_line,
  input  logic [1:0]       ext_edge,
  input  logic [1:0]       tmr_ovf,
  input  logic             t2_ovf,
  input  logic             t2_evt,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic [3:0]       sw_clr,
  input  logic             ack_fire,
  input  logic [VEC_W-1:0] ack_vec,
  output logic [N_SRC-1:0] req
);
  logic [1:0] ext_req_w;
  logic [1:0] tmr_flag_w;
  logic t2_ovf_q, t2_evt_q, rx_q, tx_q;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_ext
      logic smp, eflag;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          smp   <= 1'b0;
          eflag <= 1'b0;
        end else begin
          smp <= ext_line[g];
          if (ext_edge[g] && ext_line[g] && !smp) eflag <= 1'b1;
          else if (ack_fire && ack_vec == VEC_W'(2 * g)) eflag <= 1'b0;
        end
      end
      assign ext_req_w[g] = ext_edge[g] ? eflag : smp;
    end

    for (g = 0; g < 2; g++) begin : g_tmr
      logic dly, flag;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dly  <= 1'b0;
          flag <= 1'b0;
        end else begin
          dly <= tmr_ovf[g];
          if (dly) flag <= 1'b1;
          else if (ack_fire && ack_vec == VEC_W'(2 * g + 1)) flag <= 1'b0;
        end
      end
      assign tmr_flag_w[g] = flag;

      // R8
      tmr_ackclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && ack_vec == VEC_W'(2 * g + 1) && !dly) |=> !flag);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t2_ovf_q <= 1'b0;
      t2_evt_q <= 1'b0;
      rx_q     <= 1'b0;
      tx_q     <= 1'b0;
    end else begin
      if (t2_ovf) t2_ovf_q <= 1'b1; else if (sw_clr[0]) t2_ovf_q <= 1'b0;
      if (t2_evt) t2_evt_q <= 1'b1; else if (sw_clr[1]) t2_evt_q <= 1'b0;
      if (ser_rx) rx_q     <= 1'b1; else if (sw_clr[2]) rx_q     <= 1'b0;
      if (ser_tx) tx_q     <= 1'b1; else if (sw_clr[3]) tx_q     <= 1'b0;
    end
  end

  assign req = {t2_ovf_q | t2_evt_q, rx_q | tx_q, tmr_flag_w[1],
                ext_req_w[1], tmr_flag_w[0], ext_req_w[0]};

  // R7
  t2_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_ovf_q && !sw_clr[0]) |=> t2_ovf_q);
  // R9
  ser_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_q && !sw_clr[2]) |=> rx_q);
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic             en_wr,
  input  logic [EN_W-1:0]  en_wdata,
  output logic [EN_W-1:0]  en_rdata,
  input  logic             irq_ack,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vec,
  output logic             ack_fire
);
  logic [EN_W-1:0]  en_q;
  logic [N_SRC-1:0] pend;
  logic             pend_any;

  assign pend     = gate_req(req, en_q);
  assign pend_any = |pend;
  assign ack_fire = irq_valid && irq_ack;
  assign en_rdata = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (en_wr) en_q <= en_wdata & EN_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
    end else if (ack_fire) begin
      irq_valid <= 1'b0;
    end else if (!irq_valid && pend_any) begin
      irq_valid <= 1'b1;
      irq_vec   <= first_pending(pend);
    end
  end

  // R11
  hold_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_vec)));
  // R3
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[MASTER_BIT] && !irq_valid) |=> !irq_valid);
  // R4
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> !en_rdata[RSV_BIT]);
  // R1
  issue_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(pend_any));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ext_line,
  input  logic [1:0] ext_edge,
  input  logic [1:0] tmr_ovf,
  input  logic       t2_ovf,
  input  logic       t2_evt,
  input  logic       ser_rx,
  input  logic       ser_tx,
  input  logic [3:0] sw_clr,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  output logic [7:0] en_rdata,
  output logic       irq_valid,
  output logic [2:0] irq_vec,
  input  logic       irq_ack
);
  logic [N_SRC-1:0] req;
  logic             ack_fire;

  irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ext_line(ext_line), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .t2_ovf(t2_ovf), .t2_evt(t2_evt),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .sw_clr(sw_clr),
    .ack_fire(ack_fire), .ack_vec(irq_vec), .req(req)
  );

  irq_select u_sel (
    .clk(clk), .rst_n(rst_n), .req(req), .en_wr(en_wr),
    .en_wdata(en_wdata), .en_rdata(en_rdata), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .ack_fire(ack_fire)
  );
endmodule

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ext_line = '0, ext_edge = '0, tmr_ovf = '0;
  logic t2_ovf = 0, t2_evt = 0, ser_rx = 0, ser_tx = 0;
  logic [3:0] sw_clr = '0;
  logic en_wr = 0;
  logic [7:0] en_wdata = '0;
  logic [7:0] en_rdata;
  logic irq_valid;
  logic [2:0] irq_vec;
  logic irq_ack = 0;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_hub i_irq_hub (
    .clk(clk), .rst_n(rst_n), .ext_line(ext_line), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .t2_ovf(t2_ovf), .t2_evt(t2_evt), .ser_rx(ser_rx),
    .ser_tx(ser_tx), .sw_clr(sw_clr), .en_wr(en_wr), .en_wdata(en_wdata),
    .en_rdata(en_rdata), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .irq_ack(irq_ack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one edge, then settle at the falling edge
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_wr = 1; en_wdata = v; tick(); en_wr = 0;
  endtask

  task automatic ack(input logic [3:0] clr = 4'h0);
    irq_ack = 1; sw_clr = clr; tick(); irq_ack = 0; sw_clr = 4'h0;
  endtask

  task automatic t_reset;
    chk("R5 enable after reset", en_rdata, 0);
    chk("R5 valid after reset", irq_valid, 0);
  endtask

  task automatic t_enable_reg;
    wr_en(8'hFF);
    chk("R2/R4 readback of 0xFF", en_rdata, 8'hBF);
    wr_en(8'h40);
    chk("R4 reserved bit write", en_rdata, 0);
    chk("R4 no vector from reserved", irq_valid, 0);
  endtask

  task automatic t_timer2;
    wr_en(8'hA0);
    t2_ovf = 1; tick(); t2_ovf = 0;
    chk("R6 t2 not yet valid", irq_valid, 0);
    tick();
    chk("R6 t2 valid one edge later", irq_valid, 1);
    chk("R1 t2 vector code", irq_vec, 5);
    ack();
    chk("R7 valid drops on ack", irq_valid, 0);
    tick();
    chk("R7 t2 re-presented after ack", irq_valid, 1);
    ack(4'b0001);
    tick(2);
    chk("R7 t2 gone after sw clear", irq_valid, 0);
  endtask

  task automatic t_timer0;
    wr_en(8'h82);
    tmr_ovf = 2'b01; tick(); tmr_ovf = 2'b00;
    tick();
    chk("R6 t0 not valid after one edge", irq_valid, 0);
    tick();
    chk("R6 t0 valid two edges later", irq_valid, 1);
    chk("R1 t0 vector code", irq_vec, 1);
    ack();
    tick(2);
    chk("R8 t0 flag cleared by ack", irq_valid, 0);
  endtask

  task automatic t_priority;
    wr_en(8'h3F);
    tmr_ovf = 2'b11; ser_rx = 1; t2_evt = 1; ext_line = 2'b00;
    tick(); tmr_ovf = 0; ser_rx = 0; t2_evt = 0;
    tick(3);
    chk("R3 master off blocks all", irq_valid, 0);
    wr_en(8'hBF);
    tick();
    chk("R1 first issued is t0", irq_vec, 1);
    chk("R1 valid with master on", irq_valid, 1);
    tmr_ovf = 2'b00; tick(3);
    chk("R11 vector held", irq_vec, 1);
    chk("R11 valid held", irq_valid, 1);
    ack(); tick();
    chk("R1 next is t1", irq_vec, 3);
    ack(); tick();
    chk("R1 next is serial", irq_vec, 4);
    ack(); tick();
    chk("R9 serial kept after ack", irq_vec, 4);
    ack(4'b0100); tick();
    chk("R9 after rx clear timer 2 follows", irq_vec, 5);
    ack(4'b0010); tick(2);
    chk("R7 event flag cleared", irq_valid, 0);
  endtask

  task automatic t_external;
    ext_edge = 2'b00;
    wr_en(8'h81);
    ext_line = 2'b01; tick();
    chk("R10 level not yet valid", irq_valid, 0);
    tick();
    chk("R10 level valid", irq_valid, 1);
    chk("R1 ext0 vector code", irq_vec, 0);
    ack(); tick();
    chk("R10 level line re-presents", irq_valid, 1);
    ext_line = 2'b00; tick();
    ack(); tick(2);
    chk("R10 level released", irq_valid, 0);
    ext_edge = 2'b10;
    wr_en(8'h84);
    ext_line = 2'b10; tick(2);
    chk("R10 edge mode valid", irq_valid, 1);
    chk("R1 ext1 vector code", irq_vec, 2);
    ack(); tick(2);
    chk("R8 edge flag cleared while line high", irq_valid, 0);
    ext_line = 2'b00; tick();
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable_reg();
    t_timer2();
    t_timer0();
    t_priority();
    t_external();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule